// File: doc/BRIEF.md
# Serial Gain-Control Register with Step Decode

This block is the digital control front end of a programmable-gain stage. A host drives three wires: a serial data bit, a clock, and an active-low enable. While the enable is low, each rising clock edge pushes one data bit, most significant first, into a seven-bit shift path. When the enable returns high, the shifted contents move into a holding latch. Nothing downstream sees a partial word.

The latched seven-bit code is turned into a gain setting. The step index follows the code up to a ceiling of 71 and stays at 71 for every higher code. The gain output is a signed fixed-point value in units of 0.0001 dB. Each step adds 0.7526 dB, and step 71 corresponds to +26 dB. The host can send the usual eight-bit word: its leading bit falls out of the seven-bit path, so eight-bit codes 128 to 255 act exactly like codes 0 to 127. Words shorter than seven bits are accepted, and whatever the register holds at that moment is latched.

Top module: `gain_ctl_serial`

## Requirements
- R1: While `ser_en_n` is low, each rising edge of `clk` shifts `ser_din` into the least significant end of a 7-bit register. Earlier bits move one place toward the most significant end, so a 7-bit word sent MSB first ends up in its natural order.
- R2: When an 8-bit word is sent MSB first, only its lower seven bits are latched. Its top bit is discarded, so word values N and N+128 give identical outputs.
- R3: A low-to-high transition of `ser_en_n` is detected at the first rising `clk` edge that samples it high after sampling it low. At that edge the register contents are copied into `code_o`.
- R4: `code_o`, `step_o` and `gain_o` stay unchanged at every other clock edge, including every edge that shifts a bit.
- R5: Rising `clk` edges that sample `ser_en_n` high leave the shift register unchanged, whatever `ser_din` does.
- R6: `step_o` equals `code_o` when `code_o` is 71 or less, and equals 71 when `code_o` is between 72 and 127.
- R7: `gain_o` is a 20-bit two's-complement value equal to 260000 − (71 − `step_o`) × 7526. It is +260000 at step 71 and −274346 at step 0.
- R8: While reset is asserted, and after reset is released, the shift register and the latch read zero. This makes `code_o` = 0, `step_o` = 0 and `gain_o` = −274346.
- R9: If fewer than seven bits are shifted before the enable rises, the register is latched as it stands. The new bits sit at the low end, and the older contents move up by the number of bits sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_din | input | 1 | Serial data bit, most significant bit first |
| ser_en_n | input | 1 | Active-low enable: shifting while low, transfer to latch on its rise |
| code_o | output | 7 | Latched 7-bit gain code |
| step_o | output | 7 | Effective gain step, clamped at 71 |
| gain_o | output | 20 | Signed gain in 0.0001 dB units |

## Verification
The bench concentrates on the clamp boundary: codes 70, 71, 72 and 127, and 8-bit words whose top bit is set. A decoder with an off-by-one ceiling would report step 72 or wrap the gain, and a nine-bit path would let the leading bit alter the code. It checks the outputs at every shifting edge, because a design that copies the register into the latch on each clock would show intermediate codes there. It also toggles data during idle edges and sends short words. A register that shifts regardless of the enable, or that clears before each word, would then latch a value different from the expected shifted-through one.

// File: rtl/gcs_pkg.sv
package gcs_pkg;
  localparam int CODE_W     = 7;
  localparam int STEP_MAX   = 71;
  localparam int STEP_DB_E4 = 7526;
  localparam int TOP_DB_E4  = 260000;
  localparam int GAIN_W     = 20;

  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/gcs_rst_sync.sv
module gcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ns = chain_q[STAGES-1];
endmodule

// File: rtl/gcs_shifter.sv
module gcs_shifter #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic              en_n,
  output logic [CODE_W-1:0] sreg,
  output logic              load
);
  logic [CODE_W-1:0] sreg_q, sreg_d;
  logic              en_q;
  logic              shift_en;

  // Shift only on edges that sample the enable low (R1, R5)
  assign shift_en = ~en_n;
  // Rising enable seen in the clk domain (R3)
  assign load     = en_n & ~en_q;

  always_comb begin
    sreg_d = sreg_q;
    if (shift_en) sreg_d = {sreg_q[CODE_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      en_q   <= 1'b1;
    end else begin
      sreg_q <= sreg_d;
      en_q   <= en_n;
    end
  end

  assign sreg = sreg_q;
endmodule

// File: rtl/gcs_latch.sv
module gcs_latch #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] dout
);
  logic [CODE_W-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (load) hold_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign dout = hold_q;
endmodule

// File: rtl/gcs_decode.sv
module gcs_decode #(
  parameter int CODE_W     = 7,
  parameter int STEP_MAX   = 71,
  parameter int STEP_DB_E4 = 7526,
  parameter int TOP_DB_E4  = 260000,
  parameter int GAIN_W     = 20
) (
  input  logic [CODE_W-1:0]        code,
  output logic [CODE_W-1:0]        step,
  output logic signed [GAIN_W-1:0] gain
);
  localparam logic [CODE_W-1:0] CEIL = CODE_W'(STEP_MAX);

  int gain_int;

  always_comb begin
    step     = (code > CEIL) ? CEIL : code;
    gain_int = TOP_DB_E4 - (STEP_MAX - int'(step)) * STEP_DB_E4;
    gain     = GAIN_W'(gain_int);
  end
endmodule

// File: rtl/gain_ctl_serial.sv
module gain_ctl_serial
  import gcs_pkg::*;
#(
  parameter int P_CODE_W     = CODE_W,
  parameter int P_STEP_MAX   = STEP_MAX,
  parameter int P_STEP_DB_E4 = STEP_DB_E4,
  parameter int P_TOP_DB_E4  = TOP_DB_E4,
  parameter int P_GAIN_W     = GAIN_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_din,
  input  logic                       ser_en_n,
  output logic [P_CODE_W-1:0]        code_o,
  output logic [P_CODE_W-1:0]        step_o,
  output logic signed [P_GAIN_W-1:0] gain_o
);
  logic                rst_ns;
  logic [P_CODE_W-1:0] sreg;
  logic                load;

  gcs_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  gcs_shifter #(.CODE_W(P_CODE_W)) u_shift (
    .clk  (clk),
    .rst_n(rst_ns),
    .din  (ser_din),
    .en_n (ser_en_n),
    .sreg (sreg),
    .load (load)
  );

  gcs_latch #(.CODE_W(P_CODE_W)) u_latch (
    .clk  (clk),
    .rst_n(rst_ns),
    .load (load),
    .din  (sreg),
    .dout (code_o)
  );

  gcs_decode #(
    .CODE_W    (P_CODE_W),
    .STEP_MAX  (P_STEP_MAX),
    .STEP_DB_E4(P_STEP_DB_E4),
    .TOP_DB_E4 (P_TOP_DB_E4),
    .GAIN_W    (P_GAIN_W)
  ) u_dec (
    .code(code_o),
    .step(step_o),
    .gain(gain_o)
  );
endmodule

// File: rtl/gcs_checker.sv
module gcs_checker (
  input logic              clk,
  input logic              rst_ns,
  input logic              en_n,
  input logic [6:0]        code,
  input logic [6:0]        step,
  input logic signed [19:0] gain
);
  logic en_prev;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) en_prev <= 1'b1;
    else         en_prev <= en_n;
  end

  // R4: latched code moves only after an enable rise
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    !(en_n && !en_prev) |=> $stable(code));

  // R6: step never exceeds the ceiling
  assert_step_ceiling_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    step <= 7'd71);

  // R6: below the ceiling the step follows the code
  assert_step_tracks_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (code <= 7'd71) |-> (step == code));

  // R7: top of range
  assert_gain_top_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    (step == 7'd71) |-> (gain == 20'sd260000));

  // R7: bottom of range
  assert_gain_floor_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    (step == 7'd0) |-> (gain == -20'sd274346));
endmodule

bind gain_ctl_serial gcs_checker u_chk (
  .clk   (clk),
  .rst_ns(rst_ns),
  .en_n  (ser_en_n),
  .code  (code_o),
  .step  (step_o),
  .gain  (gain_o)
);

// File: tb/test_gain_ctl_serial.sv
module test_gain_ctl_serial;
  logic clk;
  logic rst_n;
  logic ser_din;
  logic ser_en_n;
  logic [6:0] code_o;
  logic [6:0] step_o;
  logic signed [19:0] gain_o;

  int n_run;
  int n_fail;
  bit done;
  logic [6:0] m_sreg;
  logic [6:0] m_code;

  gain_ctl_serial i_gain_ctl_serial (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_din (ser_din),
    .ser_en_n(ser_en_n),
    .code_o  (code_o),
    .step_o  (step_o),
    .gain_o  (gain_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int exp_step(input logic [6:0] c);
    return (int'(c) > 71) ? 71 : int'(c);
  endfunction

  function automatic int exp_gain(input logic [6:0] c);
    return 260000 - (71 - exp_step(c)) * 7526;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    check(req, int'(code_o), int'(m_code));
    check(req, int'(step_o), exp_step(m_code));
    check(req, int'(gain_o), exp_gain(m_code));
  endtask

  // Shift n bits (MSB first) then raise the enable; checks hold and transfer
  task automatic send(input int n, input logic [15:0] bits);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      check("R4 hold while shifting", int'(code_o), int'(m_code));
      ser_en_n = 1'b0;
      ser_din  = bits[i];
      m_sreg   = {m_sreg[5:0], bits[i]};
    end
    @(negedge clk);
    check("R4 hold after last shift", int'(code_o), int'(m_code));
    ser_en_n = 1'b1;
    ser_din  = 1'($urandom);
    @(negedge clk);
    m_code = m_sreg;
    check_outputs("R3 transfer on enable rise");
  endtask

  initial begin
    process::self().srandom(32'd7133);
    n_run = 0; n_fail = 0; done = 1'b0;
    m_sreg = '0; m_code = '0;
    rst_n = 1'b0; ser_en_n = 1'b1; ser_din = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset code", int'(code_o), 0);
    check("R8 reset gain", int'(gain_o), -274346);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outputs("R8 after reset release");

    // R1: plain 7-bit word
    send(7, 16'h0055);
    check("R1 seven-bit word", int'(code_o), 'h55);
    // R2: 8-bit word with top bit set, lower bits 71 -> clamp boundary
    send(8, 16'h00C7);
    check("R2 top bit dropped", int'(code_o), 71);
    check("R7 gain at max", int'(gain_o), 260000);
    send(8, 16'h0080);
    check("R2 code 128 acts as 0", int'(code_o), 0);
    check("R7 gain at min", int'(gain_o), -274346);
    send(8, 16'h0048);
    check("R6 code 72 clamps", int'(step_o), 71);
    send(8, 16'h00FF);
    check("R6 code 127 clamps", int'(step_o), 71);
    send(8, 16'h0046);
    check("R6 code 70", int'(step_o), 70);
    check("R7 gain at step 70", int'(gain_o), 252474);

    // R5: idle edges with data toggling must not shift
    send(7, 16'h002A);
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      ser_en_n = 1'b1;
      ser_din  = 1'($urandom);
      check("R4 idle hold", int'(code_o), int'(m_code));
    end
    send(1, 16'h0001);
    check("R5 idle edges ignored", int'(code_o), 'h55);

    // R9: short word keeps older bits shifted up
    send(3, 16'h0002);
    check("R9 short word", int'(code_o), 'h2A);

    // Random words of mixed length
    for (int r = 0; r < 60; r++) begin
      int len;
      int gap;
      len = 1 + int'($urandom_range(9));
      gap = int'($urandom_range(3));
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        ser_din = 1'($urandom);
      end
      send(len, 16'($urandom));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule